// File: doc/BRIEF.md
# Audio Clock Prescaler Search

This block picks the prescaler setting that brings a derived audio sample rate as close as it can get to a requested rate. It takes a reference clock rate and a requested sample rate as unsigned integers. The master clock runs at 384 times the sample rate, so the block first divides the reference rate by 384 to form a base rate. It then tries every 5-bit prescaler value in turn. Value i yields the base rate divided by i+1. The block keeps the value whose result lies nearest the request.

A single start pulse begins the search. One restoring divider is shared, and it serves every division in order: first the base rate, then each of the 32 candidates. When candidate 31 has been judged, the block raises done. It then presents the winning value on two identical prescaler outputs, together with the absolute error of that value. The result stays on the outputs until the next accepted start.

Top module: `audio_prescale_search`

## Requirements
- R1: After reset, done is 0, both prescaler outputs are 0 and the error output is 0x0000FFFF.
- R2: The base rate is floor(ref_rate / 384), where 384 is the RATIO parameter.
- R3: Candidate i, for i from 0 to 31, yields floor(base / (i+1)). Its error is the absolute difference between that value and req_rate, computed on unsigned 32-bit values without wrap-around.
- R4: The chosen prescaler is the candidate with the smallest error. A later candidate wins only when its error is strictly smaller, so on a tie the lower index is kept.
- R5: The running best error starts at 0x0000FFFF and the running choice starts at 0. If no candidate has an error below 0x0000FFFF, the result is prescaler 0 with error 0x0000FFFF.
- R6: presc_a and presc_b always carry the same chosen value.
- R7: done goes low on the clock edge that accepts start. It goes high 1089 edges after that edge, which is 33 divisions of 33 cycles each. It then stays high until the next accepted start.
- R8: A start pulse that arrives while a search is running is ignored, together with the input values presented with it. The running search ends on its original schedule, with the result for the inputs latched when it started.
- R9: When done is high, err_out equals the error of the chosen candidate, or 0x0000FFFF in the case of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when the block is idle |
| ref_rate | input | 32 | Reference clock rate, latched at start |
| req_rate | input | 32 | Requested sample rate, latched at start |
| presc_a | output | 5 | Chosen prescaler, first copy |
| presc_b | output | 5 | Chosen prescaler, second copy |
| err_out | output | 32 | Absolute error of the chosen prescaler |
| done | output | 1 | Search finished; result valid |

## Verification
The bench builds the block with its default parameters: 32-bit rates, a ratio of 384 and a 5-bit prescaler.

At this width the extreme cases are reachable. A reference rate of all ones gives errors that never drop below the initial best. A zero reference gives an error that would wrap if subtracted naively.

Small reference rates give small base rates. These make exact ties between neighbouring candidates reachable. They also give quotients that fall to zero, so the zero-request case picks a high index.

// File: rtl/audio_prescale_search.sv
module audio_prescale_search #(
  parameter int          W        = 32,
  parameter int          RATIO    = 384,
  parameter int          PW       = 5,
  parameter logic [31:0] ERR_INIT = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  ref_rate,
  input  logic [W-1:0]  req_rate,
  output logic [PW-1:0] presc_a,
  output logic [PW-1:0] presc_b,
  output logic [W-1:0]  err_out,
  output logic          done
);
  localparam int NCAND = 1 << PW;
  localparam int CW    = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_EVAL} st_t;

  st_t           st;
  logic          base_ph;
  logic [PW-1:0] idx, best_idx;
  logic [CW-1:0] cnt;
  logic [W:0]    rem;
  logic [W-1:0]  quo, dvs, base, req_q, best_err;
  logic          done_q;

  wire [W:0]   trial = {rem[W-1:0], quo[W-1]};
  wire         fits  = trial >= {1'b0, dvs};
  wire [W-1:0] diff  = (req_q >= quo) ? (req_q - quo) : (quo - req_q);
  wire         last  = idx == PW'(NCAND - 1);

  assign presc_a = best_idx;
  assign presc_b = best_idx;
  assign err_out = best_err;
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_ph  <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      rem      <= '0;
      quo      <= '0;
      dvs      <= '0;
      base     <= '0;
      req_q    <= '0;
      best_idx <= '0;
      best_err <= W'(ERR_INIT);
      done_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          req_q    <= req_rate;
          quo      <= ref_rate;
          rem      <= '0;
          dvs      <= W'(RATIO);
          cnt      <= '0;
          base_ph  <= 1'b1;
          idx      <= '0;
          best_idx <= '0;
          best_err <= W'(ERR_INIT);
          done_q   <= 1'b0;
          st       <= S_DIV;
        end
        S_DIV: begin
          if (fits) begin
            rem <= trial - {1'b0, dvs};
            quo <= {quo[W-2:0], 1'b1};
          end else begin
            rem <= trial;
            quo <= {quo[W-2:0], 1'b0};
          end
          if (cnt == CW'(W - 1)) st <= S_EVAL;
          else cnt <= cnt + 1'b1;
        end
        S_EVAL: begin
          rem <= '0;
          cnt <= '0;
          if (base_ph) begin
            base    <= quo;
            dvs     <= W'(1);
            base_ph <= 1'b0;
            st      <= S_DIV;
          end else begin
            if (diff < best_err) begin
              best_err <= diff;
              best_idx <= idx;
            end
            if (last) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
              quo <= base;
              dvs <= W'(idx) + W'(2);
              st  <= S_DIV;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_best_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> best_err <= $past(best_err));

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE && idx != $past(idx)) |-> idx == $past(idx) + 1'b1);

  p_err_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_out <= W'(ERR_INIT));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> req_q == $past(req_q));
endmodule

// File: tb/audio_prescale_search_test.sv
module audio_prescale_search_test;
  localparam int LAT = 1089;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_rate = '0, req_rate = '0;
  logic [4:0]  presc_a, presc_b;
  logic [31:0] err_out;
  logic        done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  audio_prescale_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_rate(ref_rate), .req_rate(req_rate),
    .presc_a(presc_a), .presc_b(presc_b), .err_out(err_out), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] rf, input logic [31:0] rq,
                                output int bi, output longint be);
    longint b = rf / 384;
    be = 64'hFFFF;
    bi = 0;
    for (int i = 0; i < 32; i++) begin
      longint q = b / (i + 1);
      longint e = (rq > q) ? rq - q : q - rq;
      if (e < be) begin be = e; bi = i; end
    end
  endfunction

  task automatic run_case(input string name, input logic [31:0] rf, input logic [31:0] rq,
                          input string tag, input bit poke_busy);
    int ei, n;
    longint ee;
    model(rf, rq, ei, ee);
    @(negedge clk);
    ref_rate = rf; req_rate = rq; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, {"R7 done clears ", name}, done, 0);
    n = 1;
    while (n < 5000) begin
      if (poke_busy && n == 200) begin
        ref_rate = 32'd7680; req_rate = 32'd8; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) break;
      n++;
    end
    chk(n == LAT, {"R7 latency ", name}, n, LAT);
    chk(presc_a == 5'(ei), {tag, " presc ", name}, presc_a, ei);
    chk(presc_b == presc_a, {"R6 copies ", name}, presc_b, presc_a);
    chk(err_out == 32'(ee), {"R9 error ", name}, err_out, ee);
    repeat (5) @(negedge clk);
    chk(done && presc_a == 5'(ei), {"R7 hold ", name}, done, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(presc_a == 0 && presc_b == 0, "R1 presc", presc_a, 0);
    chk(err_out == 32'hFFFF, "R1 err", err_out, 32'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    run_case("typical", 32'd50_000_000, 32'd44100, "R2", 0);
    run_case("exact", 32'd73_728_000, 32'd48000, "R3", 0);
    chk(presc_a == 5'd3 && err_out == 0, "R3 exact idx", presc_a, 3);
    run_case("tie", 32'd7680, 32'd8, "R4", 0);
    chk(presc_a == 5'd1, "R4 tie lower index", presc_a, 1);
    run_case("zero_req", 32'd7680, 32'd0, "R3", 0);
    chk(presc_a == 5'd20, "R3 zero quotient idx", presc_a, 20);
    run_case("no_wrap", 32'd0, 32'hFFFF_FFFF, "R5", 0);
    chk(presc_a == 0 && err_out == 32'hFFFF, "R5 init kept", err_out, 32'hFFFF);
    run_case("big_ref", 32'hFFFF_FFFF, 32'd0, "R5", 0);
    chk(presc_a == 0 && err_out == 32'hFFFF, "R5 big ref", err_out, 32'hFFFF);
    run_case("ignored", 32'd50_000_000, 32'd22050, "R8", 1);
    chk(presc_a != 5'd1, "R8 restart ignored", presc_a, 5);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule